// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It takes the received frame as a byte stream with start, end and error markers. It packs the bytes into 32-bit words and stores them in fixed 128-byte buffers in system memory. Each buffer is described by a two-word descriptor in a ring whose base address is given on an input. A frame longer than one buffer continues through as many descriptors as it needs. When the engine has filled a buffer it writes a status word with the first/last markers, the length and the destination class. It then hands the descriptor to software by setting its ownership bit.

Software frees descriptors by clearing the ownership bit. The engine reports two sticky flags. One says a complete frame has been stored. The other says a descriptor was still held by software when the engine needed it. Each flag is cleared by a one-cycle clear pulse. Memory access goes through a simple word-wide master port. A request stays up until the memory acknowledges it.

Top module: `rx_ring_writer`

## Requirements
- R1: A memory request (mem_req) that has not yet seen mem_ack keeps mem_req, mem_we and mem_addr unchanged in the next cycle. Descriptor fetches are reads; all other accesses are writes.
- R2: A descriptor is two words: the address word at the descriptor pointer and the status word at pointer+4. In the address word, bit 0 is ownership and bit 1 is wrap, and the buffer address is the word with its two low bits cleared. Frame byte k of a buffer lands in bits [8j+7:8j] of the word at buffer+4*(k/4), with j = k mod 4. Unused lanes of a frame's final word read as zero.
- R3: Only a descriptor whose ownership bit reads 0 is filled. After filling it, the engine rewrites its address word with bit 0 set, the wrap bit kept and the same buffer address.
- R4: After handing over a descriptor, the pointer moves to ring_base if that descriptor's wrap bit was set, and otherwise to the current pointer + 8. The first descriptor used after reset is at ring_base.
- R5: Each buffer takes at most 128 bytes, and a longer frame continues in the following descriptors. A frame of exactly 128 bytes uses a single descriptor.
- R6: In the status word, bit 14 marks the first buffer of a frame and bit 15 the last. Bits 31, 30 and 29 carry rx_cast[2], rx_cast[1] and rx_cast[0] (broadcast, multicast, unicast), sampled with the end byte; they appear only in the last buffer. All other bits outside the length are zero.
- R7: Bits 11:0 of the last buffer's status word hold the total frame length in bytes, for frames of up to 1536 bytes. Status words of earlier buffers hold zero there.
- R8: frame_rcvd becomes 1 when the last descriptor of a frame is handed over. A clr_rcvd pulse clears it, and a set in the same cycle wins.
- R9: If a fetched descriptor is still owned by software, buf_unavail becomes 1 and the rest of the frame is consumed without being stored. The pointer stays on that descriptor, and the next frame starts there. A clr_unavail pulse clears the flag.
- R10: A byte accepted with rx_err aborts the frame. The buffer being filled is not handed over, frame_rcvd is not set, the pointer does not move, and bytes up to the end marker are discarded.
- R11: Bytes that arrive outside a frame without rx_sof are accepted and discarded, and touch no memory.
- R12: After reset, frame_rcvd, buf_unavail and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first descriptor of the ring |
| rx_valid | input | 1 | A received byte is present |
| rx_ready | output | 1 | The byte is taken in this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Frame is bad; abort at this byte |
| rx_cast | input | 3 | Destination class {broadcast, multicast, unicast}, valid with the end byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| clr_rcvd | input | 1 | Pulse: clear frame_rcvd |
| clr_unavail | input | 1 | Pulse: clear buf_unavail |
| frame_rcvd | output | 1 | Sticky: a complete frame was stored |
| buf_unavail | output | 1 | Sticky: a needed descriptor was owned by software |

## Verification
Several rules are checked by assertions on every cycle:
- a request stays stable while it waits for its acknowledge;
- a hand-over sets the ownership bit with the fetched buffer address;
- the pointer steps by eight or returns to the ring base;
- no buffer write leaves its 128-byte window;
- intermediate status words carry a zero length;
- both flags rise only after a hand-over or a busy fetch.

Other behaviour shows only in the bench's scenarios, which inspect memory after each frame:
- the byte order inside words and the zero padding;
- the exact status words;
- a frame split over three buffers with wrap;
- the exactly-128-byte case;
- aborted frames, and stray bytes outside a frame;
- resuming after a busy descriptor, both at frame start and in mid-frame.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  localparam int WORD_W = 32;
  localparam int DESC_STRIDE = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FILL, S_WDATA, S_WSTAT, S_WOWN, S_DROP
  } wr_state_t;

  // Next descriptor pointer: back to the ring base on wrap, else one stride on.
  function automatic logic [WORD_W-1:0] next_desc(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] base,
    input logic              wrap
  );
    return wrap ? base : cur + WORD_W'(DESC_STRIDE);
  endfunction

  // Status word: class flags on top, last/first markers, 12-bit length at the bottom.
  function automatic logic [WORD_W-1:0] make_status(
    input logic [11:0] len,
    input logic        first,
    input logic        last,
    input logic [2:0]  cast
  );
    return {cast, 13'b0, last, first, 2'b00, len};
  endfunction

endpackage

// File: rtl/rx_byte_packer.sv
module rx_byte_packer #(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     clear,
  input  logic [7:0]               din,
  output logic [LANES*8-1:0]       word,
  output logic [$clog2(LANES)-1:0] lane
);
  localparam int LW = $clog2(LANES);

  logic [7:0] lane_q [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) lane <= '0;
    else if (push)       lane <= lane + LW'(1);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clear)               lane_q[j] <= '0;
      else if (push && lane == LW'(j))   lane_q[j] <= din;
    end
    assign word[8*j +: 8] = lane_q[j];
  end

endmodule

// File: rtl/rx_desc_ptr.sv
module rx_desc_ptr
  import rx_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base,
  input  logic              prime,
  input  logic              advance,
  input  logic              wrap,
  output logic [WORD_W-1:0] ptr
);
  logic primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      primed <= 1'b0;
    end else if (advance) begin
      ptr    <= next_desc(ptr, base, wrap);
      primed <= 1'b1;
    end else if (prime && !primed) begin
      ptr    <= base;
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic [2:0]  rx_cast,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        clr_rcvd,
  input  logic        clr_unavail,
  output logic        frame_rcvd,
  output logic        buf_unavail
);
  localparam int LANES  = WORD_W / 8;
  localparam int CNT_W  = $clog2(BUF_BYTES) + 1;
  localparam int WOFS_W = $clog2(BUF_BYTES) - $clog2(LANES);

  wr_state_t         st;
  logic [31:0]       buf_addr;
  logic              wrap_q, first_q, last_q;
  logic [2:0]        cast_q;
  logic [LEN_W-1:0]  frame_len;
  logic [CNT_W-1:0]  buf_cnt;
  logic [WOFS_W-1:0] wofs;
  logic [31:0]       pk_word;
  logic [$clog2(LANES)-1:0] pk_lane;
  logic [31:0]       desc_ptr;

  // Named internal events
  logic byte_take, ev_byte, ev_abort, ev_fetch_ok, ev_fetch_busy, ev_handoff, ev_wdone, buf_full;

  assign rx_ready      = (st == S_IDLE && !(rx_valid && rx_sof)) || st == S_FILL || st == S_DROP;
  assign byte_take     = rx_valid && rx_ready;
  assign ev_byte       = st == S_FILL && byte_take && !rx_err;
  assign ev_abort      = st == S_FILL && byte_take && rx_err;
  assign ev_fetch_ok   = st == S_FETCH && mem_ack && !mem_rdata[0];
  assign ev_fetch_busy = st == S_FETCH && mem_ack && mem_rdata[0];
  assign ev_handoff    = st == S_WOWN && mem_ack;
  assign ev_wdone      = st == S_WDATA && mem_ack;
  assign buf_full      = buf_cnt == CNT_W'(BUF_BYTES);

  rx_byte_packer #(.LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(ev_byte), .clear(ev_abort || ev_wdone),
    .din(rx_data), .word(pk_word), .lane(pk_lane)
  );

  rx_desc_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .base(ring_base), .prime(st == S_IDLE),
    .advance(ev_handoff), .wrap(wrap_q), .ptr(desc_ptr)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    case (st)
      S_FETCH: mem_req = 1'b1;
      S_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_addr + 32'({wofs, 2'b00});
        mem_wdata = pk_word;
      end
      S_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + 32'd4;
        mem_wdata = make_status(last_q ? 12'(frame_len) : 12'd0, first_q, last_q,
                                last_q ? cast_q : 3'b000);
      end
      S_WOWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {buf_addr[31:2], wrap_q, 1'b1};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      buf_addr  <= '0;
      wrap_q    <= 1'b0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      cast_q    <= '0;
      frame_len <= '0;
      buf_cnt   <= '0;
      wofs      <= '0;
    end else begin
      case (st)
        S_IDLE: if (rx_valid && rx_sof) begin
          st        <= S_FETCH;
          first_q   <= 1'b1;
          last_q    <= 1'b0;
          frame_len <= '0;
        end
        S_FETCH: if (ev_fetch_ok) begin
          buf_addr <= {mem_rdata[31:2], 2'b00};
          wrap_q   <= mem_rdata[1];
          buf_cnt  <= '0;
          st       <= S_FILL;
        end else if (ev_fetch_busy) begin
          st <= S_DROP;
        end
        S_FILL: if (ev_abort) begin
          st <= rx_eof ? S_IDLE : S_DROP;
        end else if (ev_byte) begin
          wofs      <= buf_cnt[WOFS_W+1:2];
          buf_cnt   <= buf_cnt + CNT_W'(1);
          frame_len <= frame_len + LEN_W'(1);
          if (rx_eof) begin
            last_q <= 1'b1;
            cast_q <= rx_cast;
          end
          if (rx_eof || pk_lane == 2'(LANES - 1)) st <= S_WDATA;
        end
        S_WDATA: if (mem_ack) st <= (last_q || buf_full) ? S_WSTAT : S_FILL;
        S_WSTAT: if (mem_ack) st <= S_WOWN;
        S_WOWN: if (mem_ack) begin
          first_q <= 1'b0;
          st      <= last_q ? S_IDLE : S_FETCH;
        end
        S_DROP: if (byte_take && rx_eof) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_rcvd  <= 1'b0;
      buf_unavail <= 1'b0;
    end else begin
      if (ev_handoff && last_q) frame_rcvd <= 1'b1;
      else if (clr_rcvd)        frame_rcvd <= 1'b0;
      if (ev_fetch_busy)        buf_unavail <= 1'b1;
      else if (clr_unavail)     buf_unavail <= 1'b0;
    end
  end

  // R1: a pending request stays put until acknowledged
  a_r1_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3: hand-over marks ownership and returns the fetched buffer address
  a_r3_handoff_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handoff |-> mem_wdata[0] && mem_wdata[31:2] == buf_addr[31:2]);

  // R4: pointer steps by one descriptor or returns to the base
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handoff |=> desc_ptr == $past(wrap_q ? ring_base : desc_ptr + 32'd8));

  // R5: data writes stay inside the current buffer
  a_r5_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st == S_WDATA) |-> (mem_addr - buf_addr) < 32'(BUF_BYTES));

  // R7: intermediate status words carry no length
  a_r7_mid_len_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st == S_WSTAT && !last_q) |-> mem_wdata[11:0] == 12'd0);

  // R8: frame flag only rises after the last hand-over
  a_r8_rcvd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_rcvd) |-> $past(ev_handoff && last_q));

  // R9: unavailable flag only rises after a fetch found a busy descriptor
  a_r9_unavail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_unavail) |-> $past(ev_fetch_busy));

endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ring_base;
  logic        rx_valid, rx_ready, rx_sof, rx_eof, rx_err;
  logic [7:0]  rx_data;
  logic [2:0]  rx_cast;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        clr_rcvd, clr_unavail, frame_rcvd, buf_unavail;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] mem [4096];

  always #2.5 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .rx_cast(rx_cast),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .clr_rcvd(clr_rcvd), .clr_unavail(clr_unavail),
    .frame_rcvd(frame_rcvd), .buf_unavail(buf_unavail)
  );

  // Memory model: acknowledge one cycle after the request appears
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    end
  end

  function automatic int dsc(int i); return 32'h1000 + 8 * i; endfunction
  function automatic int bfa(int i); return 32'h2000 + 128 * i; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_buf(string tag, int b, int start, int n, int seed);
    int bad = 0;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] e = '0;
      for (int j = 0; j < 4; j++)
        if (w * 4 + j < n) e[8*j +: 8] = 8'(seed + start + w * 4 + j);
      if (mem[(bfa(b) >> 2) + w] !== e) bad++;
    end
    chk(tag, 32'(bad), 32'd0);
  endtask

  task automatic send_frame(int len, int seed, bit err, logic [2:0] cast, bit sof_mark);
    for (int i = 0; i < len; i++) begin
      bit ok = 1'b0;
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = 8'(seed + i);
      rx_sof   = sof_mark && (i == 0);
      rx_eof   = sof_mark && (i == len - 1);
      rx_err   = err && (i == len - 1);
      rx_cast  = cast;
      while (!ok) begin
        #1 ok = rx_ready;
        @(posedge clk);
        if (!ok) @(negedge clk);
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic pulse_clear(bit r, bit u);
    @(negedge clk);
    clr_rcvd = r; clr_unavail = u;
    @(negedge clk);
    clr_rcvd = 1'b0; clr_unavail = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 frame_rcvd after reset", 32'(frame_rcvd), 32'd0);
    chk("R12 buf_unavail after reset", 32'(buf_unavail), 32'd0);
    chk("R12 mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_single;
    send_frame(10, 8'h10, 1'b0, 3'b100, 1'b1);
    check_buf("R2 short frame data and padding", 0, 0, 10, 8'h10);
    chk("R6 R7 short frame status", mem[dsc(0) >> 2 | 1], 32'h8000C00A);
    chk("R3 short frame handed over", mem[dsc(0) >> 2], 32'h00002001);
    chk("R8 frame_rcvd set", 32'(frame_rcvd), 32'd1);
    pulse_clear(1'b1, 1'b0);
    chk("R8 frame_rcvd cleared", 32'(frame_rcvd), 32'd0);
  endtask

  task automatic t_multi;
    send_frame(300, 8'h40, 1'b0, 3'b010, 1'b1);
    chk("R6 first buffer status", mem[(dsc(1) >> 2) + 1], 32'h00004000);
    chk("R7 middle buffer status", mem[(dsc(2) >> 2) + 1], 32'h00000000);
    chk("R6 R7 last buffer status", mem[(dsc(3) >> 2) + 1], 32'h4000812C);
    chk("R3 first buffer owner", mem[dsc(1) >> 2], 32'h00002081);
    chk("R3 wrap kept on hand-over", mem[dsc(3) >> 2], 32'h00002183);
    check_buf("R5 buffer 1 data", 1, 0, 128, 8'h40);
    check_buf("R5 buffer 2 data", 2, 128, 128, 8'h40);
    check_buf("R5 buffer 3 data", 3, 256, 44, 8'h40);
    chk("R8 multi frame flag", 32'(frame_rcvd), 32'd1);
  endtask

  task automatic t_busy_at_start;
    pulse_clear(1'b1, 1'b0);
    send_frame(50, 8'h60, 1'b0, 3'b001, 1'b1);
    chk("R9 buf_unavail after busy wrap target", 32'(buf_unavail), 32'd1);
    chk("R9 busy descriptor untouched", mem[(dsc(0) >> 2) + 1], 32'h8000C00A);
    chk("R9 no frame flag on drop", 32'(frame_rcvd), 32'd0);
    mem[dsc(0) >> 2] = 32'h2000;
    mem[(dsc(0) >> 2) + 1] = 32'h0;
    pulse_clear(1'b0, 1'b1);
    chk("R9 buf_unavail cleared", 32'(buf_unavail), 32'd0);
  endtask

  task automatic t_exact;
    send_frame(128, 8'h77, 1'b0, 3'b001, 1'b1);
    chk("R4 R5 exact buffer lands at ring base", mem[(dsc(0) >> 2) + 1], 32'h2000C080);
    chk("R5 exact buffer single descriptor", mem[dsc(1) >> 2], 32'h00002081);
    check_buf("R5 exact buffer data", 0, 0, 128, 8'h77);
  endtask

  task automatic t_error_and_junk;
    mem[dsc(1) >> 2] = 32'h2080; mem[(dsc(1) >> 2) + 1] = 32'h0;
    mem[dsc(2) >> 2] = 32'h2100; mem[(dsc(2) >> 2) + 1] = 32'h0;
    mem[dsc(3) >> 2] = 32'h2182; mem[(dsc(3) >> 2) + 1] = 32'h0;
    pulse_clear(1'b1, 1'b0);
    send_frame(20, 8'h30, 1'b1, 3'b100, 1'b1);
    chk("R10 aborted buffer not handed over", mem[dsc(1) >> 2], 32'h00002080);
    chk("R10 no frame flag on abort", 32'(frame_rcvd), 32'd0);
    chk("R10 no status on abort", mem[(dsc(1) >> 2) + 1], 32'h0);
    send_frame(6, 8'hE0, 1'b0, 3'b000, 1'b0);
    chk("R11 stray bytes leave descriptor free", mem[dsc(1) >> 2], 32'h00002080);
    chk("R11 stray bytes set no flag", 32'(frame_rcvd), 32'd0);
    send_frame(5, 8'h99, 1'b0, 3'b100, 1'b1);
    chk("R10 R11 next frame reuses same descriptor", mem[(dsc(1) >> 2) + 1], 32'h8000C005);
    chk("R3 next frame owner", mem[dsc(1) >> 2], 32'h00002081);
    check_buf("R2 five byte frame padding", 1, 0, 5, 8'h99);
  endtask

  task automatic t_busy_mid;
    pulse_clear(1'b1, 1'b0);
    mem[dsc(3) >> 2] = 32'h2183;
    send_frame(200, 8'h05, 1'b0, 3'b010, 1'b1);
    chk("R9 first part handed over", mem[dsc(2) >> 2], 32'h00002101);
    chk("R6 R7 first part status without end", mem[(dsc(2) >> 2) + 1], 32'h00004000);
    check_buf("R9 first part data", 2, 0, 128, 8'h05);
    chk("R9 buf_unavail mid frame", 32'(buf_unavail), 32'd1);
    chk("R9 no frame flag mid-frame drop", 32'(frame_rcvd), 32'd0);
    chk("R9 busy descriptor status untouched", mem[(dsc(3) >> 2) + 1], 32'h0);
    mem[dsc(3) >> 2] = 32'h2182;
    pulse_clear(1'b0, 1'b1);
    send_frame(4, 8'h20, 1'b0, 3'b001, 1'b1);
    chk("R9 resume at the busy descriptor", mem[(dsc(3) >> 2) + 1], 32'h2000C004);
    chk("R8 flag after resume", 32'(frame_rcvd), 32'd1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) mem[dsc(i) >> 2] = bfa(i) | (i == 3 ? 2 : 0);
    rst_n = 1'b0; ring_base = 32'h1000;
    rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0; rx_cast = '0;
    clr_rcvd = 1'b0; clr_unavail = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_multi;
    t_busy_at_start;
    t_exact;
    t_error_and_junk;
    t_busy_mid;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule